// File: doc/BRIEF.md
# Clock Select and Startup Sequencer

This block turns an incoming master clock into a uniform clock enable that ticks at 256 times the sample rate, whatever rate the master clock runs at. When the rate select is low the master clock already runs at 256fs, so the enable is high on every cycle. When the select is high the master clock runs at 384fs, and the block keeps two of every three cycles (enable, enable, skip). The result is an average of two thirds of the master rate, which is again 256fs.

The block also sequences start-up. While the synchronous reset is high, the datapath is held in power-down. After reset is released, the block keeps the datapath idle until it sees a genuine low-to-high transition of the asynchronous frame clock. That edge passes through a two-stage synchroniser and an edge detector. The block then leaves power-down, issues a one-cycle start pulse, and stays running until reset is asserted again.

Top module: `clksel_seq_top`

## Requirements
- R1: On every clock edge at which `rst` is sampled high, the outputs become `pwr_down`=1, `clk_en`=0 and `start_pulse`=0.
- R2: After reset is released, `pwr_down` stays 1 and `clk_en` stays 0 while `frame_clk` is held at a steady level. This holds even when `frame_clk` is already high at release, because only a low-to-high transition seen after reset counts.
- R3: Suppose the first rising clock edge to sample `frame_clk` high follows a low sample. Then `pwr_down` falls and `start_pulse` rises after the third rising edge counted from that one. `start_pulse` lasts exactly one cycle.
- R4: While running with `sel_384`=0, `clk_en` is 1 on every cycle.
- R5: While running with `sel_384`=1, `clk_en` follows the repeating pattern 1,1,0. The pattern starts with the first running cycle.
- R6: While `sel_384` is 0 the divider phase is held at its start. When `sel_384` turns 1 during running, the pattern 1,1,0 begins in that same cycle.
- R7: Once running, the block ignores further `frame_clk` edges. It raises no more start pulses and keeps `pwr_down`=0 until reset.
- R8: A reset during running returns the block to power-down. A new `frame_clk` rising edge is then needed to start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; holds power-down |
| sel_384 | input | 1 | Rate select: 0 = master at 256fs, 1 = master at 384fs |
| frame_clk | input | 1 | Frame clock, asynchronous to `clk` |
| clk_en | output | 1 | 256fs internal clock enable |
| pwr_down | output | 1 | High while the datapath is held in power-down |
| start_pulse | output | 1 | One-cycle pulse when internal timing begins |

## Verification
The assertions take `sel_384` as a level that changes only between clock edges. They check the 1,1,0 window from the first edge at which the select is sampled high, or from the first running edge. They also assume reset is seen on a clock edge, since it is synchronous. The bench changes every input on the falling edge of the clock. It holds `frame_clk` low for several cycles before each intended rising edge, so each start is caused by a clean, single transition.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // Sequencer state: held down or running.
    typedef enum logic [0:0] {
        ST_DOWN = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Status word handed from the sequencer to the top.
    typedef struct packed {
        logic run;
        logic pwr_down;
        logic start;
    } seq_status_t;

    // Width of a counter that spans 0..den-1 (minimum one bit).
    function automatic int phase_width(input int den);
        return (den > 1) ? $clog2(den) : 1;
    endfunction

endpackage

// File: rtl/clksel_edge_sync.sv
module clksel_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    // Reset to ones: a level already high at release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            hist_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            hist_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/clksel_rate_div.sv
module clksel_rate_div
    import clksel_pkg::*;
#(
    parameter int DEN  = 3,
    parameter int KEEP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic frac_mode,
    output logic en
);
    localparam int PW = phase_width(DEN);

    logic [PW-1:0] phase_q;

    // Phase only advances in fractional mode; otherwise parked at zero.
    always_ff @(posedge clk) begin
        if (rst || !run || !frac_mode) begin
            phase_q <= '0;
        end else if (phase_q == PW'(DEN - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign en = run & (~frac_mode | (phase_q < PW'(KEEP)));
endmodule

// File: rtl/clksel_startup_fsm.sv
module clksel_startup_fsm
    import clksel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_rise,
    output seq_status_t status
);
    run_state_e state_q;
    logic       start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DOWN;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (state_q == ST_DOWN && frame_rise) begin
                state_q <= ST_RUN;
                start_q <= 1'b1;
            end
        end
    end

    always_comb begin
        status.run      = (state_q == ST_RUN);
        status.pwr_down = (state_q != ST_RUN);
        status.start    = start_q;
    end
endmodule

// File: rtl/clksel_seq_top.sv
module clksel_seq_top
    import clksel_pkg::*;
#(
    parameter int DEN         = 3,
    parameter int KEEP        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_384,
    input  logic frame_clk,
    output logic clk_en,
    output logic pwr_down,
    output logic start_pulse
);
    logic        frame_rise;
    seq_status_t status;

    clksel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (frame_clk),
        .rise     (frame_rise)
    );

    clksel_startup_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .frame_rise (frame_rise),
        .status     (status)
    );

    clksel_rate_div #(.DEN(DEN), .KEEP(KEEP)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (status.run),
        .frac_mode (sel_384),
        .en        (clk_en)
    );

    assign pwr_down    = status.pwr_down;
    assign start_pulse = status.start;
endmodule

// File: rtl/clksel_seq_checker.sv
module clksel_seq_checker #(
    parameter int DEN  = 3,
    parameter int KEEP = 2
) (
    input logic clk,
    input logic rst,
    input logic sel_384,
    input logic clk_en,
    input logic pwr_down,
    input logic start_pulse
);
    logic       rst_seen_q;
    logic [7:0] pos_q;
    logic [7:0] hits_q;

    always_ff @(posedge clk) rst_seen_q <= rst;

    // Window tracker for the fractional pattern.
    always_ff @(posedge clk) begin
        if (rst || pwr_down || !sel_384 || pos_q == 8'(DEN - 1)) begin
            pos_q  <= '0;
            hits_q <= '0;
        end else begin
            pos_q  <= pos_q + 8'd1;
            hits_q <= hits_q + 8'(clk_en);
        end
    end

    // R1: outputs forced quiet after a reset edge
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            a_r1_reset_quiet: assert (pwr_down && !clk_en && !start_pulse)
                else $error("R1 outputs not quiet after reset");
        end
    end

    // R2: no enable while held down
    a_r2_down_no_enable: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !clk_en);

    // R3: start pulse marks the leaving of power-down and lasts one cycle
    a_r3_start_edge: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (!pwr_down && $past(pwr_down)));
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R4: whole-rate mode enables every cycle
    a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && !sel_384) |-> clk_en);

    // R5: exactly KEEP enables in each DEN-cycle window
    a_r5_keep_count: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down && sel_384 && pos_q == 8'(DEN - 1)) |-> (hits_q + 8'(clk_en) == 8'(KEEP)));

    // R7: running is sticky until reset
    a_r7_stay_running: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |=> !pwr_down);
endmodule

bind clksel_seq_top clksel_seq_checker #(.DEN(DEN), .KEEP(KEEP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_384     (sel_384),
    .clk_en      (clk_en),
    .pwr_down    (pwr_down),
    .start_pulse (start_pulse)
);

// File: tb/clksel_seq_top_test.sv
module clksel_seq_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_384 = 1'b0;
    logic frame_clk = 1'b0;
    logic clk_en, pwr_down, start_pulse;

    int checks = 0;
    int fails  = 0;

    clksel_seq_top uut (
        .clk         (clk),
        .rst         (rst),
        .sel_384     (sel_384),
        .frame_clk   (frame_clk),
        .clk_en      (clk_en),
        .pwr_down    (pwr_down),
        .start_pulse (start_pulse)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with a chosen frame level and select, then release.
    task automatic do_reset(input logic lvl, input logic sel);
        rst = 1'b1; frame_clk = lvl; sel_384 = sel;
        step(3);
        rst = 1'b0;
    endtask

    task automatic t_reset_state;
        rst = 1'b1; frame_clk = 1'b1;
        step(1);
        check("R1 pwr_down in reset", pwr_down, 1);
        check("R1 clk_en in reset", clk_en, 0);
        check("R1 start_pulse in reset", start_pulse, 0);
    endtask

    task automatic t_steady_frame;
        do_reset(1'b1, 1'b0);
        step(10);
        check("R2 frame held high: pwr_down", pwr_down, 1);
        check("R2 frame held high: clk_en", clk_en, 0);
        frame_clk = 1'b0;
        step(10);
        check("R2 frame held low: pwr_down", pwr_down, 1);
    endtask

    // Frame is low here; raise it and watch the start latency (R3), then full rate (R4).
    task automatic t_launch_full_rate;
        int bad = 0;
        frame_clk = 1'b1;
        step(2);
        check("R3 still down two edges after", pwr_down, 1);
        step(1);
        check("R3 running after third edge", pwr_down, 0);
        check("R3 start pulse raised", start_pulse, 1);
        step(1);
        check("R3 start pulse one cycle", start_pulse, 0);
        for (int i = 0; i < 6; i++) begin
            if (clk_en !== 1'b1) bad++;
            step(1);
        end
        check("R4 enable every cycle at whole rate", bad, 0);
    endtask

    task automatic t_frac_pattern;
        do_reset(1'b0, 1'b1);
        step(3);
        frame_clk = 1'b1;
        step(3);
        check("R5 start on first running cycle", start_pulse, 1);
        for (int i = 0; i < 9; i++) begin
            check($sformatf("R5 pattern slot %0d", i), clk_en, (i % 3 != 2) ? 1 : 0);
            step(1);
        end
    endtask

    task automatic t_sel_switch;
        sel_384 = 1'b0;
        #1;
        check("R6 whole rate after select low", clk_en, 1);
        step(4);
        sel_384 = 1'b1;
        #1;
        check("R6 pattern slot 0 after select high", clk_en, 1);
        for (int i = 1; i < 6; i++) begin
            step(1);
            check($sformatf("R6 pattern slot %0d after select high", i), clk_en, (i % 3 != 2) ? 1 : 0);
        end
    endtask

    task automatic t_ignore_frames;
        int extra = 0;
        for (int k = 0; k < 4; k++) begin
            frame_clk = ~frame_clk;
            for (int j = 0; j < 4; j++) begin
                step(1);
                if (start_pulse !== 1'b0 || pwr_down !== 1'b0) extra++;
            end
        end
        check("R7 no restart or power-down on later frames", extra, 0);
    endtask

    task automatic t_rerun;
        rst = 1'b1; frame_clk = 1'b0;
        step(1);
        check("R8 power-down on reset while running", pwr_down, 1);
        rst = 1'b0;
        step(6);
        check("R8 stays down without new frame edge", pwr_down, 1);
        frame_clk = 1'b1;
        step(3);
        check("R8 restarted: pwr_down", pwr_down, 0);
        check("R8 restarted: start pulse", start_pulse, 1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(1);
        t_reset_state();
        t_steady_frame();
        t_launch_full_rate();
        t_frac_pattern();
        t_sel_switch();
        t_ignore_frames();
        t_rerun();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule